// File: doc/BRIEF.md
# Requester Stream Protocol Checker

This block is a passive monitor that sits beside the AXI4-Stream interface a requester uses to send memory requests. It drives nothing back onto the stream. It only watches `valid`, `ready`, data, keep, last and user. It follows packet boundaries with a small state machine. It catches sender mistakes while they happen: valid dropping inside a packet, the beat changing while the receiver stalls, keep bits with holes or an early partial beat, illegal byte-enable pairs, payloads above the programmed maximum size, and payloads that cross a 4 KB page.

Every beat is 128 bits by default, so four Dwords. The first beat of a packet carries the 16-byte request descriptor in Dwords 0 to 3. The checker decodes three descriptor fields: the Dword address (bits 63:2), the Dword count (bits 74:64) and the request type (bits 78:75, where 4'b0001 means memory write). Byte enables arrive in the user bus on the first beat: first-Dword enables in bits 3:0 and last-Dword enables in bits 7:4.

The checker reports at most one violation per packet. It raises a one-cycle pulse with a 3-bit code. It also pulses a nullify flag once the errored packet has finished.

State machine:
- **ST_IDLE** waits for a packet start.
- **ST_HEAD_BAD** holds a stalled first beat that has already been reported.
- **ST_BODY** is the middle of a clean packet.
- **ST_BODY_BAD** is the middle of a reported packet.

Transitions:
- **ST_IDLE → ST_IDLE**: a single-beat packet is accepted, or valid is low.
- **ST_IDLE → ST_BODY**: the first beat is accepted clean without last.
- **ST_IDLE → ST_BODY_BAD**: the first beat is accepted with a violation and without last.
- **ST_IDLE → ST_HEAD_BAD**: a stalled first beat shows a violation.
- **ST_HEAD_BAD → ST_IDLE**: the beat is accepted with last, or valid is withdrawn.
- **ST_HEAD_BAD → ST_BODY_BAD**: the beat is accepted without last.
- **ST_BODY → ST_BODY_BAD**: a violation occurs.
- **ST_BODY / ST_BODY_BAD → ST_IDLE**: the last beat is accepted.

Top module: `rq_stream_checker`

## Requirements
- R1: After reset, `err_valid`, `err_code` and `pkt_nullify` are 0. Cycles with valid low between packets never raise an error.
- R2: If valid is low in any cycle after a non-last beat was accepted and before the last beat is accepted, code 1 is reported and the packet is nullified.
- R3: If data, keep, last or user changes while valid stays high on the cycle after a valid-high, ready-low cycle, code 2 is reported.
- R4: Any of the following reports code 3: a first beat whose keep bits 3:0 are not all ones, a non-last beat whose keep is not all ones, or a last beat whose keep is zero or not a run of ones starting at bit 0.
- R5: For memory writes, any of the following reports code 4: a count of 1 with nonzero last enables; any other count with either enable field zero; a count of 3 or more with a non-contiguous enable field. Counts of 1 or 2 accept non-contiguous enables, and a count of 1 with both enables zero is legal.
- R6: For memory writes, code 5 is reported when the Dword count is 0 or when count×4 bytes exceeds the maximum size selected by `mps_sel`: 0→128, 1→256, 2→512, 3→1024 bytes.
- R7: For memory writes, code 6 is reported when the Dword address bits 9:0 plus the count exceed 1024, which means the payload crosses a 4 KB page.
- R8: When several violations appear in the same cycle, the lowest code is reported.
- R9: Only the first violation of a packet is reported. `err_valid` is a one-cycle pulse in the cycle after the offending cycle.
- R10: `pkt_nullify` pulses for one cycle in the cycle after the last-beat handshake of a packet that had a violation. It never pulses for a clean packet.
- R11: The checks of R5 to R7 apply only when the request type is memory write. Other types skip them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mps_sel | input | 2 | Maximum payload size select |
| rq_tdata | input | DATA_W | Stream data |
| rq_tkeep | input | DATA_W/32 | Per-Dword keep |
| rq_tlast | input | 1 | Last beat of packet |
| rq_tuser | input | USER_W | Sideband; byte enables on first beat |
| rq_tvalid | input | 1 | Sender valid |
| rq_tready | input | 1 | Receiver ready |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Violation code (0 when idle) |
| pkt_nullify | output | 1 | Pulse marking an errored packet as finished |

## Verification
The in-RTL assertions check on every cycle the rules that follow directly from state and ports:
- the idle quiet rule;
- a valid gap in a clean body always yielding code 1;
- a changed last flag under stall being seen as a hold violation;
- a short keep on a body beat being flagged;
- an oversized write being flagged;
- silence after a packet is already reported;
- nullify appearing only after a last-beat handshake.

Only the bench's scenarios show the rest. That includes the exact code chosen when violations compete or follow one another in time, the byte-enable and page arithmetic at their edges, the maximum-size boundaries, and the exemption of non-write requests.

// File: rtl/rqchk_pkg.sv
package rqchk_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_GAP     = 3'd1,
        ERR_HOLD    = 3'd2,
        ERR_KEEP    = 3'd3,
        ERR_BYTE_EN = 3'd4,
        ERR_SIZE    = 3'd5,
        ERR_PAGE    = 3'd6
    } rq_err_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BODY     = 2'd1,
        ST_BODY_BAD = 2'd2,
        ST_HEAD_BAD = 2'd3
    } rq_state_e;

    // descriptor field positions decoded from the first beat
    localparam int DESC_DW      = 4;
    localparam int ADDR_OFF_LO  = 2;
    localparam int ADDR_OFF_W   = 10;
    localparam int CNT_LO       = 64;
    localparam int CNT_W        = 11;
    localparam int TYPE_LO      = 75;
    localparam int TYPE_W       = 4;
    localparam logic [TYPE_W-1:0] TYPE_MEM_WR = 4'b0001;
    localparam int BE_W         = 4;

    // true when the enable bits form a single run of ones
    function automatic logic be_contig(input logic [BE_W-1:0] be);
        logic [BE_W-1:0] y;
        y = be;
        for (int i = 0; i < BE_W - 1; i++) begin
            if (!y[0]) y = y >> 1;
        end
        return (be != '0) && ((y & (y + 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/rqchk_hold_mon.sv
module rqchk_hold_mon #(
    parameter int DATA_W = 128,
    parameter int USER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tvalid,
    input  logic              tready,
    input  logic [DATA_W-1:0] tdata,
    input  logic [DATA_W/32-1:0] tkeep,
    input  logic              tlast,
    input  logic [USER_W-1:0] tuser,
    output logic              hold_viol
);
    localparam int KEEP_W = DATA_W / 32;
    localparam int BEAT_W = DATA_W + KEEP_W + 1 + USER_W;

    logic              stalled_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_now;

    assign beat_now = {tdata, tkeep, tlast, tuser};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled_q <= 1'b0;
            beat_q    <= '0;
        end else begin
            stalled_q <= tvalid && !tready;
            beat_q    <= beat_now;
        end
    end

    assign hold_viol = stalled_q && tvalid && (beat_now != beat_q);

    // R3: a flipped last flag under stall is always a hold violation
    assert_hold_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tvalid && !tready) && tvalid && (tlast != $past(tlast))) |-> hold_viol);

endmodule

// File: rtl/rqchk_keep_chk.sv
module rqchk_keep_chk #(
    parameter int KEEP_W = 4
) (
    input  logic [KEEP_W-1:0] tkeep,
    input  logic              tlast,
    input  logic              head_beat,
    output logic              keep_viol
);
    import rqchk_pkg::*;

    logic [KEEP_W-1:0] hole;
    logic              run_from_zero;
    logic              head_ok;
    logic              full;

    // a hole is a zero Dword below a one Dword
    assign hole[KEEP_W-1] = 1'b0;
    for (genvar i = 0; i < KEEP_W - 1; i++) begin : g_hole
        assign hole[i] = !tkeep[i] && tkeep[i+1];
    end

    assign run_from_zero = tkeep[0] && (hole == '0);
    assign full          = &tkeep;
    assign head_ok       = !head_beat || (&tkeep[DESC_DW-1:0]);
    assign keep_viol     = !head_ok || (tlast ? !run_from_zero : !full);

endmodule

// File: rtl/rqchk_desc_chk.sv
module rqchk_desc_chk (
    input  logic [rqchk_pkg::ADDR_OFF_W-1:0] page_off,
    input  logic [rqchk_pkg::CNT_W-1:0]      dw_cnt,
    input  logic [rqchk_pkg::TYPE_W-1:0]     req_type,
    input  logic [rqchk_pkg::BE_W-1:0]       first_be,
    input  logic [rqchk_pkg::BE_W-1:0]       last_be,
    input  logic [1:0]                       mps_sel,
    output logic                             be_viol,
    output logic                             size_viol,
    output logic                             page_viol
);
    import rqchk_pkg::*;

    logic        is_wr;
    logic        be_bad;
    logic [12:0] mps_bytes;
    logic [12:0] pay_bytes;
    logic [11:0] page_end;

    assign is_wr = (req_type == TYPE_MEM_WR);

    always_comb begin
        if (dw_cnt == CNT_W'(1)) begin
            be_bad = (last_be != '0);
        end else begin
            be_bad = (first_be == '0) || (last_be == '0) ||
                     ((dw_cnt >= CNT_W'(3)) && (!be_contig(first_be) || !be_contig(last_be)));
        end
    end

    assign mps_bytes = 13'd128 << mps_sel;
    assign pay_bytes = {dw_cnt, 2'b00};
    assign page_end  = {2'b00, page_off} + {1'b0, dw_cnt};

    assign be_viol   = is_wr && be_bad;
    assign size_viol = is_wr && ((dw_cnt == '0) || (pay_bytes > mps_bytes));
    assign page_viol = is_wr && (page_end > 12'd1024);

endmodule

// File: rtl/rq_stream_checker.sv
module rq_stream_checker #(
    parameter int DATA_W = 128,
    parameter int USER_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mps_sel,
    input  logic [DATA_W-1:0]    rq_tdata,
    input  logic [DATA_W/32-1:0] rq_tkeep,
    input  logic                 rq_tlast,
    input  logic [USER_W-1:0]    rq_tuser,
    input  logic                 rq_tvalid,
    input  logic                 rq_tready,
    output logic                 err_valid,
    output logic [2:0]           err_code,
    output logic                 pkt_nullify
);
    import rqchk_pkg::*;

    localparam int KEEP_W = DATA_W / 32;

    rq_state_e state, nxt;
    rq_err_e   code;
    logic hold_viol, keep_viol, be_viol, size_viol, page_viol;
    logic in_head, in_body, gap, viol, report, hs, pkt_bad;

    assign in_head = (state == ST_IDLE) || (state == ST_HEAD_BAD);
    assign in_body = (state == ST_BODY) || (state == ST_BODY_BAD);
    assign hs      = rq_tvalid && rq_tready;
    assign gap     = in_body && !rq_tvalid;

    rqchk_hold_mon #(.DATA_W(DATA_W), .USER_W(USER_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tvalid   (rq_tvalid),
        .tready   (rq_tready),
        .tdata    (rq_tdata),
        .tkeep    (rq_tkeep),
        .tlast    (rq_tlast),
        .tuser    (rq_tuser),
        .hold_viol(hold_viol)
    );

    rqchk_keep_chk #(.KEEP_W(KEEP_W)) u_keep (
        .tkeep    (rq_tkeep),
        .tlast    (rq_tlast),
        .head_beat(in_head),
        .keep_viol(keep_viol)
    );

    rqchk_desc_chk u_desc (
        .page_off (rq_tdata[ADDR_OFF_LO +: ADDR_OFF_W]),
        .dw_cnt   (rq_tdata[CNT_LO +: CNT_W]),
        .req_type (rq_tdata[TYPE_LO +: TYPE_W]),
        .first_be (rq_tuser[BE_W-1:0]),
        .last_be  (rq_tuser[2*BE_W-1:BE_W]),
        .mps_sel  (mps_sel),
        .be_viol  (be_viol),
        .size_viol(size_viol),
        .page_viol(page_viol)
    );

    // priority: lower code wins when several appear together
    always_comb begin
        code = ERR_NONE;
        if (gap)                              code = ERR_GAP;
        else if (rq_tvalid && hold_viol)      code = ERR_HOLD;
        else if (rq_tvalid && keep_viol)      code = ERR_KEEP;
        else if (rq_tvalid && in_head && be_viol)   code = ERR_BYTE_EN;
        else if (rq_tvalid && in_head && size_viol) code = ERR_SIZE;
        else if (rq_tvalid && in_head && page_viol) code = ERR_PAGE;
    end

    assign viol    = (code != ERR_NONE);
    assign report  = viol && ((state == ST_IDLE) || (state == ST_BODY));
    assign pkt_bad = viol || (state == ST_BODY_BAD) || (state == ST_HEAD_BAD);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hs)              nxt = rq_tlast ? ST_IDLE : (viol ? ST_BODY_BAD : ST_BODY);
                else if (viol)       nxt = ST_HEAD_BAD;
            end
            ST_HEAD_BAD: begin
                if (hs)              nxt = rq_tlast ? ST_IDLE : ST_BODY_BAD;
                else if (!rq_tvalid) nxt = ST_IDLE;
            end
            ST_BODY: begin
                if (hs && rq_tlast)  nxt = ST_IDLE;
                else if (viol)       nxt = ST_BODY_BAD;
            end
            ST_BODY_BAD: begin
                if (hs && rq_tlast)  nxt = ST_IDLE;
            end
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid   <= 1'b0;
            err_code    <= ERR_NONE;
            pkt_nullify <= 1'b0;
        end else begin
            err_valid   <= report;
            err_code    <= report ? code : ERR_NONE;
            pkt_nullify <= hs && rq_tlast && pkt_bad;
        end
    end

    // R1: no error after an idle cycle with valid low
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rq_tvalid) |=> !err_valid);

    // R2: valid gap in a clean body gives code 1
    assert_gap_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && !rq_tvalid) |=> (err_valid && err_code == ERR_GAP));

    // R4: partial keep on a non-last body beat is flagged
    assert_body_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && rq_tvalid && !rq_tlast && !(&rq_tkeep)) |=> err_valid);

    // R6: oversized write on the head beat is flagged
    assert_size_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rq_tvalid && size_viol) |=> err_valid);

    // R9: a packet already reported stays silent
    assert_first_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY_BAD || state == ST_HEAD_BAD) |=> !err_valid);

    // R10: nullify only after a last-beat handshake
    assert_nullify_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_nullify |-> $past(rq_tvalid && rq_tready && rq_tlast));

endmodule

// File: tb/sim_rq_stream_checker.sv
`timescale 1ns/1ps
module sim_rq_stream_checker;

    localparam int DATA_W = 128;
    localparam int USER_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         mps_sel = 2'd0;
    logic [DATA_W-1:0]  tdata = '0;
    logic [3:0]         tkeep = '0;
    logic               tlast = 1'b0;
    logic [USER_W-1:0]  tuser = '0;
    logic               tvalid = 1'b0;
    logic               tready = 1'b0;
    logic               err_valid;
    logic [2:0]         err_code;
    logic               pkt_nullify;

    int n_checks = 0;
    int n_fail   = 0;
    int n_err    = 0;
    int n_null   = 0;
    int got_code = 0;

    always #4 clk = ~clk;

    rq_stream_checker #(.DATA_W(DATA_W), .USER_W(USER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mps_sel(mps_sel),
        .rq_tdata(tdata), .rq_tkeep(tkeep), .rq_tlast(tlast), .rq_tuser(tuser),
        .rq_tvalid(tvalid), .rq_tready(tready),
        .err_valid(err_valid), .err_code(err_code), .pkt_nullify(pkt_nullify)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (err_valid) begin
                n_err++;
                got_code = int'(err_code);
            end
            if (pkt_nullify) n_null++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit be_ok_run(input logic [3:0] be);
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b0110,
            4'b1100, 4'b0111, 4'b1110, 4'b1111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit last_keep_ok(input logic [3:0] k);
        return (k == 4'b0001) || (k == 4'b0011) || (k == 4'b0111) || (k == 4'b1111);
    endfunction

    // expected first violation of a packet, in time order then code order
    function automatic int exp_code(input logic [3:0] typ, input int n, input int off,
                                    input logic [3:0] fbe, input logic [3:0] lbe,
                                    input int mps, input int nb, input logic [3:0] lk,
                                    input int gap_at, input int hold_at, input int hole_at);
        logic [3:0] k0;
        bit wr, be_bad, sz_bad, pg_bad;
        wr = (typ == 4'b0001);
        k0 = (nb == 1) ? lk : ((hole_at == 0) ? 4'b0111 : 4'b1111);
        if (n == 1) be_bad = (lbe != 0);
        else be_bad = (fbe == 0) || (lbe == 0) || (n >= 3 && (!be_ok_run(fbe) || !be_ok_run(lbe)));
        sz_bad = (n == 0) || (n * 4 > (128 << mps));
        pg_bad = (off + n) > 1024;
        if (k0 != 4'b1111) return 3;
        if (wr && be_bad) return 4;
        if (wr && sz_bad) return 5;
        if (wr && pg_bad) return 6;
        if (hold_at == 0) return 2;
        if (gap_at == 0 && nb > 1) return 1;
        for (int b = 1; b < nb; b++) begin
            logic [3:0] kb;
            bit lastb;
            lastb = (b == nb - 1);
            kb = lastb ? lk : ((b == hole_at) ? 4'b0111 : 4'b1111);
            if (lastb ? !last_keep_ok(kb) : (kb != 4'b1111)) return 3;
            if (hold_at == b) return 2;
            if (gap_at == b && !lastb) return 1;
        end
        return 0;
    endfunction

    task automatic run_pkt(input string req, input logic [3:0] typ, input int n,
                           input logic [61:0] dwa, input logic [3:0] fbe, input logic [3:0] lbe,
                           input int nb, input logic [3:0] lk,
                           input int gap_at, input int hold_at, input int hole_at);
        int ec;
        logic [DATA_W-1:0] desc;
        ec = exp_code(typ, n, int'(dwa[9:0]), fbe, lbe, int'(mps_sel), nb, lk, gap_at, hold_at, hole_at);
        n_err = 0; n_null = 0; got_code = 0;
        desc = {$urandom, $urandom, $urandom, $urandom};
        desc[63:0]  = {dwa, 2'b00};
        desc[74:64] = n[10:0];
        desc[78:75] = typ;
        for (int b = 0; b < nb; b++) begin
            int cyc;
            bit acc;
            tdata  = (b == 0) ? desc : {$urandom, $urandom, $urandom, $urandom};
            tlast  = (b == nb - 1);
            tkeep  = tlast ? lk : ((b == hole_at) ? 4'b0111 : 4'b1111);
            tuser  = (b == 0) ? {lbe, fbe} : 8'h00;
            tvalid = 1'b1;
            cyc = 0;
            acc = 1'b0;
            while (!acc) begin
                if (hold_at == b && cyc == 0) tready = 1'b0;
                else tready = ($urandom_range(0, 3) != 0);
                if (hold_at == b && cyc == 1) tdata[100] = ~tdata[100];
                acc = tready;
                @(posedge clk); #1;
                cyc++;
            end
            if (gap_at == b && b < nb - 1) begin
                tvalid = 1'b0;
                tready = $urandom_range(0, 1);
                @(posedge clk); #1;
            end
        end
        tvalid = 1'b0; tlast = 1'b0; tready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check({req, " code"}, got_code, ec);
        check({req, " pulses"}, n_err, (ec != 0) ? 1 : 0);
        check({req, " nullify"}, n_null, (ec != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 err_valid", int'(err_valid), 0);
        check("R1 err_code", int'(err_code), 0);
        check("R1 nullify", int'(pkt_nullify), 0);
        n_err = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            tdata = {$urandom, $urandom, $urandom, $urandom};
            tkeep = 4'($urandom); tlast = 1'($urandom); tready = 1'($urandom);
        end
        tvalid = 1'b0;
        @(posedge clk); #1;
        check("R1 idle quiet", n_err, 0);

        mps_sel = 2'd0;
        run_pkt("R10 clean", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 3, 4'hF, -1, -1, -1);
        run_pkt("R2 gap", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 3, 4'hF, 0, -1, -1);
        run_pkt("R3 hold", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 3, 4'hF, -1, 1, -1);
        run_pkt("R3 hold head", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, 0, -1);
        run_pkt("R4 hole", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 3, 4'hF, -1, -1, 1);
        run_pkt("R4 last keep", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 2, 4'b0101, -1, -1, -1);
        run_pkt("R4 head keep", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 1, 4'b0111, -1, -1, -1);
        run_pkt("R5 one dw last_be", 4'b0001, 1, 62'd0, 4'hF, 4'h1, 2, 4'b0001, -1, -1, -1);
        run_pkt("R5 zero length", 4'b0001, 1, 62'd0, 4'h0, 4'h0, 2, 4'b0001, -1, -1, -1);
        run_pkt("R5 two dw sparse", 4'b0001, 2, 62'd0, 4'b1010, 4'b0101, 2, 4'b0011, -1, -1, -1);
        run_pkt("R5 three dw sparse", 4'b0001, 3, 62'd0, 4'b1010, 4'hF, 2, 4'b0111, -1, -1, -1);
        run_pkt("R5 zero first_be", 4'b0001, 4, 62'd0, 4'h0, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R6 at limit", 4'b0001, 32, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R6 over limit", 4'b0001, 33, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R6 zero count", 4'b0001, 0, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        mps_sel = 2'd3;
        run_pkt("R6 1024 ok", 4'b0001, 256, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R6 1024 over", 4'b0001, 257, 62'd0, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R7 page edge", 4'b0001, 4, 62'd1020, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R7 page cross", 4'b0001, 5, 62'd1020, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        mps_sel = 2'd0;
        run_pkt("R8 size and page", 4'b0001, 40, 62'd1020, 4'hF, 4'hF, 2, 4'hF, -1, -1, -1);
        run_pkt("R9 first only", 4'b0001, 8, 62'd0, 4'hF, 4'hF, 4, 4'hF, 2, -1, 1);
        run_pkt("R11 non-write", 4'b0000, 40, 62'd1020, 4'h0, 4'h5, 2, 4'hF, -1, -1, -1);

        for (int p = 0; p < 250; p++) begin
            logic [3:0] typ, fbe, lbe, lk;
            logic [61:0] dwa;
            int n, nb, ga, ha, ka;
            mps_sel = 2'($urandom);
            typ = ($urandom_range(0, 3) == 0) ? 4'b0000 : 4'b0001;
            n = ($urandom_range(0, 1) != 0) ? $urandom_range(1, 4) : $urandom_range(0, 300);
            dwa = {$urandom, $urandom};
            if ($urandom_range(0, 1) != 0) dwa[9:0] = 10'(1024 - n + $urandom_range(0, 2) - 1);
            fbe = 4'($urandom); lbe = 4'($urandom);
            if ($urandom_range(0, 1) != 0) begin
                fbe = 4'hF;
                lbe = (n == 1) ? 4'h0 : 4'hF;
            end
            nb = $urandom_range(1, 5);
            lk = ($urandom_range(0, 9) < 7) ? (4'hF >> $urandom_range(0, 3)) : 4'($urandom);
            ga = (nb > 1 && $urandom_range(0, 9) == 0) ? $urandom_range(0, nb - 2) : -1;
            ha = ($urandom_range(0, 9) == 0) ? $urandom_range(0, nb - 1) : -1;
            ka = (nb > 1 && $urandom_range(0, 9) == 0) ? $urandom_range(0, nb - 2) : -1;
            run_pkt("R8 random", typ, n, dwa, fbe, lbe, nb, lk, ga, ha, ka);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

endmodule